// File: doc/BRIEF.md
# Interlocked asynchronous read requester

This block is the requesting end of a fully interlocked read handshake on a shared address/data bus whose far end runs without a common clock. A local client hands it an address with a one-cycle start pulse. The block raises its request line and drives the address onto the shared lines through a tristate-style output enable. It then follows the remote side's acknowledge and data-ready lines through a fixed sequence. Every step waits for a level change from the far end: acknowledge high, acknowledge low, data-ready high, then data-ready low. The block captures the data word at the data-ready step and answers with its own acknowledge.

Both remote control lines pass through two-flop synchronizers before the sequencer looks at them. A programmable limit bounds the time spent in any one waiting step. When the limit is exceeded, the block withdraws every bus line, returns to idle and pulses an error output. A start pulse that comes while a read is in progress is dropped, and the busy output shows that condition. The local side has no back-pressure. The done pulse lasts one cycle and is never held off. The captured word stays on the data output until the next read completes.

Top module: `hs_read_master`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy, done, err_timeout, bus_req_o, bus_ad_oe_o and bus_mack_o are all 0.
- R2: A start pulse sampled while idle makes bus_req_o and bus_ad_oe_o go to 1 in the next cycle, with bus_ad_o equal to the start_addr of that pulse, and busy goes to 1 at the same time.
- R3: Each of bus_sack_i and bus_drdy_i passes through two synchronizing flops. The sequencer reacts at the third rising edge after the raw line changes. Request and address enable both drop one cycle after the synchronized acknowledge is seen high.
- R4: After the request is withdrawn, the block waits for the synchronized acknowledge to go low and then for synchronized data-ready to go high. At that edge it latches bus_ad_i into rd_data and raises bus_mack_o.
- R5: bus_mack_o drops one cycle after synchronized data-ready is seen low. At the same time done is 1 for exactly one cycle and busy returns to 0. rd_data holds its value until the next completed read.
- R6: bus_ad_oe_o is 1 only in the request phase, exactly when bus_req_o is 1. It is never 1 while bus_mack_o is 1.
- R7: With tmo_limit = L > 0, a waiting step that sees no progress for L+1 consecutive cycles ends the transaction. In the next cycle all bus outputs and busy are 0, and err_timeout is 1 for one cycle. tmo_limit = 0 disables the timeout.
- R8: When progress from the far end and limit expiry fall in the same cycle, the progress wins. The sequence advances and no error is raised.
- R9: A start pulse sampled while busy is ignored. It changes neither bus_ad_o nor the sequence, and no extra request follows the current read. A start sampled in the cycle where done is 1 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle read start from the local side |
| start_addr | input | BUS_W | Address for the read being started |
| tmo_limit | input | TMO_W | Wait limit in cycles, 0 disables the timeout |
| busy | output | 1 | A read is in progress |
| done | output | 1 | One-cycle pulse on normal completion |
| rd_data | output | BUS_W | Last captured data word |
| err_timeout | output | 1 | One-cycle pulse when a read is abandoned |
| bus_req_o | output | 1 | Read request control line |
| bus_ad_oe_o | output | 1 | Output enable for the shared address/data lines |
| bus_ad_o | output | BUS_W | Address value driven when enabled |
| bus_ad_i | input | BUS_W | Value sensed on the shared lines |
| bus_sack_i | input | 1 | Acknowledge from the far end, asynchronous |
| bus_drdy_i | input | 1 | Data-ready from the far end, asynchronous |
| bus_mack_o | output | 1 | Acknowledge from this block to the far end |

## Verification
Two things can land on the same edge: the far end's synchronized progress and the expiry of the wait limit. The bench sweeps the limit against the emulated far end's response delay. The sweep passes through the case where the acknowledge shows up at the sequencer in exactly the cycle the limit runs out. A behavioural model expects the sequence to advance with no error pulse in that case. A second collision is a new start placed in the done cycle. The model expects it to be accepted, with the request back up in the next cycle.

// File: rtl/hsr_pkg.sv
package hsr_pkg;

  localparam int unsigned IDX_IDLE  = 0;
  localparam int unsigned IDX_REQ   = 1;
  localparam int unsigned IDX_ACKLO = 2;
  localparam int unsigned IDX_DRDY  = 3;
  localparam int unsigned IDX_DACK  = 4;
  localparam int unsigned N_STATES  = 5;

  // one-hot: each bus control line comes straight from one state flop
  typedef enum logic [N_STATES-1:0] {
    ST_IDLE  = 5'b00001,
    ST_REQ   = 5'b00010,
    ST_ACKLO = 5'b00100,
    ST_DRDY  = 5'b01000,
    ST_DACK  = 5'b10000
  } hsr_state_e;

  localparam int unsigned CTRL_ACK  = 0;
  localparam int unsigned CTRL_DRDY = 1;
  localparam int unsigned N_CTRL    = 2;

endpackage

// File: rtl/hsr_sync.sv
module hsr_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] pipe_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[g] <= '0;
          else        pipe_q[g] <= async_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[g] <= '0;
          else        pipe_q[g] <= pipe_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = pipe_q[STAGES-1];

endmodule

// File: rtl/hsr_timer.sv
module hsr_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (restart)         cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (limit != '0) && (cnt_q >= limit);

  AST_CNT_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0)) else $error("counter not cleared"); // R7

endmodule

// File: rtl/hsr_fsm.sv
module hsr_fsm
  import hsr_pkg::*;
#(
  parameter int unsigned BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BUS_W-1:0] start_addr,
  input  logic             ack_s,
  input  logic             drdy_s,
  input  logic             expired,
  input  logic [BUS_W-1:0] bus_ad_i,
  output logic             restart,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [BUS_W-1:0] rd_data,
  output logic             bus_req_o,
  output logic             bus_ad_oe_o,
  output logic [BUS_W-1:0] bus_ad_o,
  output logic             bus_mack_o
);

  hsr_state_e       st_q, st_d;
  logic             progress;
  logic             abort;
  logic [BUS_W-1:0] addr_q;
  logic [BUS_W-1:0] data_q;
  logic             done_q;
  logic             err_q;

  always_comb begin
    progress = 1'b0;
    st_d     = st_q;
    unique case (st_q)
      ST_IDLE:  if (start) st_d = ST_REQ;
      ST_REQ: begin
        progress = ack_s;
        if (ack_s) st_d = ST_ACKLO;
      end
      ST_ACKLO: begin
        progress = !ack_s;
        if (!ack_s) st_d = ST_DRDY;
      end
      ST_DRDY: begin
        progress = drdy_s;
        if (drdy_s) st_d = ST_DACK;
      end
      ST_DACK: begin
        progress = !drdy_s;
        if (!drdy_s) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    abort = (st_q != ST_IDLE) && !progress && expired;
    if (abort) st_d = ST_IDLE;
  end

  assign restart = (st_d != st_q) || (st_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      data_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == ST_DACK) && !drdy_s;
      err_q  <= abort;
      if ((st_q == ST_IDLE) && start) addr_q <= start_addr;
      if ((st_q == ST_DRDY) && drdy_s) data_q <= bus_ad_i;
    end
  end

  assign bus_req_o   = st_q[IDX_REQ];
  assign bus_ad_oe_o = st_q[IDX_REQ];
  assign bus_mack_o  = st_q[IDX_DACK];
  assign bus_ad_o    = addr_q;
  assign busy        = !st_q[IDX_IDLE];
  assign done        = done_q;
  assign err         = err_q;
  assign rd_data     = data_q;

  AST_OE_ONLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ad_oe_o |-> (bus_req_o && !bus_mack_o)) else $error("oe outside request"); // R6

  AST_REQ_DROP_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req_o) |-> ($past(ack_s) || err_q)) else $error("request dropped early"); // R3

  AST_MACK_DROP_ON_DRDY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_mack_o) |-> (!$past(drdy_s) || err_q)) else $error("mack dropped early"); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q) else $error("done longer than a cycle"); // R5

  AST_ERR_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (!busy && !bus_req_o && !bus_mack_o && !done_q)) else $error("bus held after timeout"); // R7

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(addr_q)) else $error("address changed while busy"); // R9

  AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(st_q)) else $error("state not one-hot"); // R1

endmodule

// File: rtl/hs_read_master.sv
module hs_read_master
  import hsr_pkg::*;
#(
  parameter int unsigned BUS_W       = 16,
  parameter int unsigned TMO_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BUS_W-1:0] start_addr,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             busy,
  output logic             done,
  output logic [BUS_W-1:0] rd_data,
  output logic             err_timeout,
  output logic             bus_req_o,
  output logic             bus_ad_oe_o,
  output logic [BUS_W-1:0] bus_ad_o,
  input  logic [BUS_W-1:0] bus_ad_i,
  input  logic             bus_sack_i,
  input  logic             bus_drdy_i,
  output logic             bus_mack_o
);

  logic [N_CTRL-1:0] ctrl_raw;
  logic [N_CTRL-1:0] ctrl_sync;
  logic              restart;
  logic              expired;

  assign ctrl_raw[CTRL_ACK]  = bus_sack_i;
  assign ctrl_raw[CTRL_DRDY] = bus_drdy_i;

  hsr_sync #(.WIDTH(N_CTRL), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (ctrl_raw),
    .sync_o  (ctrl_sync)
  );

  hsr_timer #(.CNT_W(TMO_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .limit   (tmo_limit),
    .expired (expired)
  );

  hsr_fsm #(.BUS_W(BUS_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_addr  (start_addr),
    .ack_s       (ctrl_sync[CTRL_ACK]),
    .drdy_s      (ctrl_sync[CTRL_DRDY]),
    .expired     (expired),
    .bus_ad_i    (bus_ad_i),
    .restart     (restart),
    .busy        (busy),
    .done        (done),
    .err         (err_timeout),
    .rd_data     (rd_data),
    .bus_req_o   (bus_req_o),
    .bus_ad_oe_o (bus_ad_oe_o),
    .bus_ad_o    (bus_ad_o),
    .bus_mack_o  (bus_mack_o)
  );

endmodule

// File: tb/tb_hs_read_master.sv
`timescale 1ns/1ps
module tb_hs_read_master;

  localparam int BW = 16;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [BW-1:0] start_addr = '0;
  logic [TW-1:0] tmo_limit = 16'd40;
  logic          busy, done, err_timeout, bus_req_o, bus_ad_oe_o, bus_mack_o;
  logic [BW-1:0] rd_data, bus_ad_o;
  logic [BW-1:0] bus_ad_i = 16'hA5A5;
  logic          bus_sack_i = 1'b0;
  logic          bus_drdy_i = 1'b0;

  always #2 clk = ~clk;

  hs_read_master #(.BUS_W(BW), .TMO_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .tmo_limit(tmo_limit), .busy(busy), .done(done), .rd_data(rd_data),
    .err_timeout(err_timeout), .bus_req_o(bus_req_o), .bus_ad_oe_o(bus_ad_oe_o),
    .bus_ad_o(bus_ad_o), .bus_ad_i(bus_ad_i), .bus_sack_i(bus_sack_i),
    .bus_drdy_i(bus_drdy_i), .bus_mack_o(bus_mack_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  int          m_st = 0;
  int          m_cnt = 0;
  bit          m_sa1, m_sa2, m_da1, m_da2;
  logic [BW-1:0] m_addr = '0;
  logic [BW-1:0] m_data = '0;
  bit          m_done, m_err;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_sa1 = 0; m_sa2 = 0; m_da1 = 0; m_da2 = 0;
      m_addr = '0; m_data = '0; m_done = 0; m_err = 0;
    end else begin
      bit ack, drdy, expd, prog;
      int nst;
      ack  = m_sa2;
      drdy = m_da2;
      expd = (tmo_limit != 0) && (m_cnt >= int'(tmo_limit));
      nst  = m_st;
      prog = 0;
      m_done = (m_st == 4) && !drdy;
      m_err  = 0;
      case (m_st)
        0: if (start) begin nst = 1; m_addr = start_addr; end
        1: prog = ack;
        2: prog = !ack;
        3: prog = drdy;
        4: prog = !drdy;
        default: ;
      endcase
      if (m_st != 0) begin
        if (prog) begin
          if (m_st == 3) m_data = bus_ad_i;
          nst = (m_st == 4) ? 0 : m_st + 1;
        end else if (expd) begin
          nst = 0;
          m_err = 1;
        end
      end
      if (nst != m_st || m_st == 0) m_cnt = 0; else m_cnt++;
      m_sa2 = m_sa1; m_sa1 = bus_sack_i;
      m_da2 = m_da1; m_da1 = bus_drdy_i;
      m_st = nst;
    end
  end

  int n_done_seen = 0;
  int n_err_seen = 0;

  // per-clock comparison, away from the rising edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R2 busy", busy, m_st != 0);
      chk("R2 bus_req_o", bus_req_o, m_st == 1);
      chk("R6 bus_ad_oe_o", bus_ad_oe_o, m_st == 1);
      chk("R4 bus_mack_o", bus_mack_o, m_st == 4);
      chk("R5 done", done, m_done);
      chk("R7 err_timeout", err_timeout, m_err);
      chk("R4 rd_data", rd_data, m_data);
      if (bus_ad_oe_o) chk("R9 bus_ad_o", bus_ad_o, m_addr);
      if (done) n_done_seen++;
      if (err_timeout) n_err_seen++;
    end
  end

  // emulated far end of the bus
  int sl_stage = 0;
  int sl_wait = 0;
  int sl_stop = 9;
  int d_ack = 1, d_rel = 1, d_drdy = 2, d_drop = 1;
  logic [BW-1:0] sl_data = 16'h1234;

  always @(negedge clk) begin
    if (sl_stage != sl_stop) begin
      case (sl_stage)
        0: if (bus_req_o) begin
             if (sl_wait >= d_ack) begin bus_sack_i <= 1; sl_stage = 1; sl_wait = 0; end
             else sl_wait++;
           end else sl_wait = 0;
        1: if (!bus_req_o) begin
             if (sl_wait >= d_rel) begin bus_sack_i <= 0; sl_stage = 2; sl_wait = 0; end
             else sl_wait++;
           end
        2: if (sl_wait >= d_drdy) begin
             bus_ad_i <= sl_data; bus_drdy_i <= 1; sl_stage = 3; sl_wait = 0;
           end else sl_wait++;
        3: if (bus_mack_o) begin
             if (sl_wait >= d_drop) begin
               bus_drdy_i <= 0; bus_ad_i <= ~sl_data; sl_stage = 4; sl_wait = 0;
             end else sl_wait++;
           end
        4: if (!bus_mack_o) begin sl_stage = 0; sl_data = sl_data + 16'h0101; end
        default: ;
      endcase
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    tick(1);
    while (m_st != 0) tick(1);
  endtask

  task automatic slave_clear();
    sl_stop = 9; sl_stage = 0; sl_wait = 0;
    bus_sack_i = 0; bus_drdy_i = 0;
    tick(4);
  endtask

  task automatic issue(input logic [BW-1:0] a);
    start = 1; start_addr = a;
    tick(1);
    start = 0;
  endtask

  task automatic read_ok(input logic [BW-1:0] a, input string tag);
    logic [BW-1:0] exp_d;
    int d0;
    exp_d = sl_data;
    d0 = n_done_seen;
    issue(a);
    wait_idle();
    tick(1);
    chk({tag, " R5 data word"}, rd_data, exp_d);
    chk({tag, " R5 one done"}, n_done_seen - d0, 1);
  endtask

  initial begin
    // R1: reset values
    tick(3);
    chk("R1 busy", busy, 0);
    chk("R1 req", bus_req_o, 0);
    chk("R1 oe", bus_ad_oe_o, 0);
    chk("R1 mack", bus_mack_o, 0);
    chk("R1 done", done, 0);
    chk("R1 err", err_timeout, 0);
    rst_n = 1;
    tick(1);
    chk("R1 busy after release", busy, 0);
    chk("R1 req after release", bus_req_o, 0);

    // R2/R3/R4/R5: plain read with explicit cycle checks
    issue(16'hBEEF);
    chk("R2 req next cycle", bus_req_o, 1);
    chk("R2 addr driven", bus_ad_o, 16'hBEEF);
    chk("R2 busy", busy, 1);
    wait_idle();
    tick(1);
    chk("R5 first read data", rd_data, 16'h1234);
    chk("R5 done count", n_done_seen, 1);

    // several delay patterns
    d_ack = 0; d_rel = 0; d_drdy = 0; d_drop = 0;
    read_ok(16'h0001, "fast");
    d_ack = 5; d_rel = 3; d_drdy = 7; d_drop = 4;
    read_ok(16'h0002, "slow");
    d_ack = 1; d_rel = 1; d_drdy = 2; d_drop = 1;

    // R3: request must stay up while ack is withheld
    tmo_limit = 0;
    sl_stop = 0;
    issue(16'h00C3);
    tick(60);
    chk("R3 request held", bus_req_o, 1);
    chk("R7 limit zero no abort", busy, 1);
    sl_stop = 9;
    wait_idle();
    tick(1);
    chk("R7 completes after stall", n_err_seen, 0);

    // R9: start while busy is ignored
    begin
      int d0;
      d0 = n_done_seen;
      tmo_limit = 40;
      issue(16'h1111);
      tick(2);
      issue(16'h2222);
      chk("R9 addr unchanged", bus_ad_o, 16'h1111);
      wait_idle();
      tick(10);
      chk("R9 no extra request", bus_req_o, 0);
      chk("R9 one done", n_done_seen - d0, 1);
    end

    // R9: start in the done cycle is accepted
    issue(16'h3333);
    while (!done) tick(1);
    start = 1; start_addr = 16'h4444;
    tick(1);
    start = 0;
    chk("R9 accepted on done", bus_req_o, 1);
    chk("R9 new addr", bus_ad_o, 16'h4444);
    wait_idle();
    tick(2);

    // R7: timeout in each waiting step
    for (int s = 0; s < 4; s++) begin
      int e0;
      e0 = n_err_seen;
      tmo_limit = 16'd6;
      sl_stop = s;
      issue(16'h5000 + 16'(s));
      wait_idle();
      tick(1);
      chk("R7 err pulse", n_err_seen - e0, 1);
      chk("R7 bus released", bus_req_o | bus_mack_o | busy, 0);
      slave_clear();
    end

    // R8: sweep limit against ack delay, collisions handled by the model
    for (int lim = 1; lim <= 6; lim++) begin
      for (int da = 0; da <= 6; da++) begin
        tmo_limit = 16'(lim);
        d_ack = da;
        issue(16'(lim * 16 + da));
        wait_idle();
        tick(1);
        slave_clear();
      end
    end
    d_ack = 1;
    tmo_limit = 16'd3;
    read_ok(16'h7777, "R8 tight limit");

    tick(4);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  always @(negedge clk) begin
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule